// File: doc/BRIEF.md
# Dual-Port Mailbox with Doorbell Interrupts

This block is a shared message buffer placed between an on-chip host bus and an external modem bus. Both sides read and write the same storage of 2^AW sixteen-bit words. With AW = 13 this is 16 KB; the default build uses a smaller AW. The host addresses the buffer in bytes, and the modem addresses it in 16-bit words. One location therefore appears at host byte offset 2·W and at modem word W. Host accesses are always whole 16-bit words, so host address bit 0 plays no part in the mapping.

Two words of the buffer serve as doorbells, and each doorbell signals one direction. When the modem writes a nonzero value to the host-bound doorbell, a level interrupt to the host goes high. It stays high until the host writes any value to a clear register. When the host writes a value with bit 0 set to the modem-bound doorbell, a level interrupt to the modem goes high. It stays high until the modem writes a value with bit 0 set to that same word. A doorbell write also stores its data in the word, so the receiving side can read back a code that says which event took place. Both doorbell locations can be moved through host-side registers.

The host port carries a request channel and a read-response channel, each with valid/ready. A request is taken on a cycle where both h_req_valid and h_req_ready are high. While a read response waits with h_rsp_ready low, h_req_ready stays low and no new request is taken. The modem port is a synchronous model of an asynchronous-SRAM-style port and has no back-pressure. In standard mode it uses the m_addr lines. In shared-bus mode (m_mux = 1) it uses an address latched from m_din on a cycle where m_adv is high.

Top module: `mbx_dualport`

## Requirements
- R1: After reset, both interrupt outputs are low. The host-bound doorbell register reads 2^AW-1 and the modem-bound doorbell register reads 2^AW-2.
- R2: When h_req_addr[AW+1] = 0, host byte address B selects modem word B[AW:1], and bit 0 is ignored. Data that one side writes is read back unchanged by the other side.
- R3: A host read taken at a clock edge returns h_rsp_valid with its data after that edge. While h_rsp_valid = 1 and h_rsp_ready = 0, h_rsp_rdata holds steady and h_req_ready is 0.
- R4: In standard mode (m_mux = 0), a cycle with m_cs = 1, m_oe = 1 and m_we = 0 reads word m_addr. The data appears on m_dout after that cycle's edge and holds until the next read. A cycle with m_cs = 1 and m_we = 1 writes m_din to word m_addr.
- R5: In shared-bus mode (m_mux = 1), a cycle with m_adv = 1 latches m_din[AW-1:0] as the address and performs no access. Later accesses use the latched address and ignore m_addr.
- R6: A modem write of a nonzero value to the word held in the host-bound doorbell register sets irq_host. A zero write has no effect. A host write of any value to register offset 0x0 clears irq_host.
- R7: A host write with bit 0 = 1 to the word held in the modem-bound doorbell register sets irq_modem. A modem write with bit 0 = 1 to that word clears irq_modem. Writes with bit 0 = 0 change neither interrupt.
- R8: A doorbell write stores its data in the buffer word like any other write.
- R9: When h_req_addr[AW+1] = 1, the host register region is selected by h_req_addr[3:2]: 0 is the clear register (reads 0), 1 is the host-bound doorbell word, 2 is the modem-bound doorbell word. After a doorbell word is moved, its old location acts as plain storage.
- R10: When an interrupt's set and clear conditions occur in the same cycle, the interrupt is set.
- R11: When both sides write the same word in the same cycle, the word keeps the host's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request accepted this cycle when high with valid |
| h_req_write | input | 1 | 1 = write, 0 = read |
| h_req_addr | input | AW+2 | Host byte address; the top bit selects the register region |
| h_req_wdata | input | 16 | Host write data |
| h_rsp_valid | output | 1 | Host read data valid |
| h_rsp_ready | input | 1 | Host accepts read data |
| h_rsp_rdata | output | 16 | Host read data |
| m_mux | input | 1 | Modem bus mode: 0 standard, 1 shared address/data |
| m_adv | input | 1 | Address latch strobe in shared-bus mode |
| m_cs | input | 1 | Modem chip select |
| m_we | input | 1 | Modem write enable |
| m_oe | input | 1 | Modem output enable (read) |
| m_addr | input | AW | Modem word address in standard mode |
| m_din | input | 16 | Modem write data, or the address in shared-bus mode |
| m_dout | output | 16 | Modem read data |
| irq_host | output | 1 | Level interrupt toward the host |
| irq_modem | output | 1 | Level interrupt toward the modem |

## Verification
On every cycle, the in-module assertions check that each interrupt rises only after its own set condition, falls only after its own clear condition, and stays high when set and clear meet. They also check that a doorbell register changes only when it is written and that a stalled read response holds still. Only the bench scenarios can show that data crosses correctly between the byte and word address views, and that the shared-bus address latch takes effect. The same holds for reprogrammed doorbell words, the host winning a same-word write collision, and the message code left in a doorbell word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 16;

  // host register region word select, taken from host address bits [3:2]
  typedef enum logic [1:0] {
    REG_CLR  = 2'd0,
    REG_HB   = 2'd1,
    REG_MB   = 2'd2,
    REG_NONE = 2'd3
  } mbx_reg_e;
endpackage

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_req_write,
  input  logic [AW+1:0]     h_req_addr,
  input  logic [DATA_W-1:0] h_req_wdata,
  output logic              h_rsp_valid,
  input  logic              h_rsp_ready,
  output logic [DATA_W-1:0] h_rsp_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-1:0]     mem_word,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_q,
  output logic              reg_we,
  output mbx_reg_e          reg_sel,
  input  logic [DATA_W-1:0] reg_q
);
  logic              take;
  logic              in_regs;
  logic              from_reg;
  logic [DATA_W-1:0] reg_hold;
  logic              unused_addr_lsb;

  assign h_req_ready = !h_rsp_valid || h_rsp_ready;
  assign take        = h_req_valid && h_req_ready;
  assign in_regs     = h_req_addr[AW+1];
  assign mem_word    = h_req_addr[AW:1];
  assign mem_wdata   = h_req_wdata;
  assign reg_sel     = mbx_reg_e'(h_req_addr[3:2]);
  assign unused_addr_lsb = h_req_addr[0];

  assign mem_we = take && h_req_write && !in_regs;
  assign mem_re = take && !h_req_write && !in_regs;
  assign reg_we = take && h_req_write && in_regs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rsp_valid <= 1'b0;
      from_reg    <= 1'b0;
      reg_hold    <= '0;
    end else if (take && !h_req_write) begin
      h_rsp_valid <= 1'b1;
      from_reg    <= in_regs;
      reg_hold    <= reg_q;
    end else if (h_rsp_ready) begin
      h_rsp_valid <= 1'b0;
    end
  end

  assign h_rsp_rdata = from_reg ? reg_hold : mem_q;

  // R3: a stalled response keeps both its valid and its data
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && !h_rsp_ready) |=> (h_rsp_valid && $stable(h_rsp_rdata)));
endmodule

// File: rtl/mbx_modem_if.sv
module mbx_modem_if
  import mbx_pkg::*;
#(
  parameter int AW      = 11,
  parameter bit HAS_MUX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_mux,
  input  logic              m_adv,
  input  logic              m_cs,
  input  logic              m_we,
  input  logic              m_oe,
  input  logic [AW-1:0]     m_addr,
  input  logic [DATA_W-1:0] m_din,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [AW-1:0]     acc_word,
  output logic [DATA_W-1:0] acc_wdata
);
  logic active;

  generate
    if (HAS_MUX) begin : g_mux
      logic [AW-1:0] addr_lat;
      always_ff @(posedge clk) begin
        if (!rst_n)             addr_lat <= '0;
        else if (m_mux && m_adv) addr_lat <= m_din[AW-1:0];
      end
      assign active   = m_cs && !(m_mux && m_adv);
      assign acc_word = m_mux ? addr_lat : m_addr;

      // R5: the address phase never performs an access
      a_r5_adv_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (m_mux && m_adv) |-> !(acc_wr || acc_rd));
    end else begin : g_std
      logic unused_mode;
      assign unused_mode = m_mux ^ m_adv ^ clk ^ rst_n;
      assign active      = m_cs;
      assign acc_word    = m_addr;
    end
  endgenerate

  assign acc_wr    = active && m_we;
  assign acc_rd    = active && m_oe && !m_we;
  assign acc_wdata = m_din;
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [AW-1:0]     h_word,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_q,
  input  logic              m_we,
  input  logic              m_re,
  input  logic [AW-1:0]     m_word,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_q
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // modem write first, host write last: the host keeps a same-word collision
  always_ff @(posedge clk) begin
    if (m_we) mem[m_word] <= m_wdata;
    if (h_we) mem[h_word] <= h_wdata;
    if (h_re) h_q <= mem[h_word];
    if (m_re) m_q <= mem[m_word];
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [AW-1:0]     h_word,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              reg_we,
  input  mbx_reg_e          reg_sel,
  output logic [DATA_W-1:0] reg_q,
  input  logic              m_wr,
  input  logic [AW-1:0]     m_word,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              irq_host,
  output logic              irq_modem
);
  localparam logic [AW-1:0] HB_RESET = {AW{1'b1}};
  localparam logic [AW-1:0] MB_RESET = {{(AW-1){1'b1}}, 1'b0};

  logic [AW-1:0] hb_port;
  logic [AW-1:0] mb_port;
  logic hb_set, hb_clr, mb_set, mb_clr;
  logic unused_wdata;

  assign hb_set = m_wr && (m_word == hb_port) && (|m_wdata);
  assign hb_clr = reg_we && (reg_sel == REG_CLR);
  assign mb_set = h_wr && (h_word == mb_port) && h_wdata[0];
  assign mb_clr = m_wr && (m_word == mb_port) && m_wdata[0];
  assign unused_wdata = ^h_wdata[DATA_W-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_host  <= 1'b0;
      irq_modem <= 1'b0;
    end else begin
      if (hb_set)      irq_host <= 1'b1;
      else if (hb_clr) irq_host <= 1'b0;
      if (mb_set)      irq_modem <= 1'b1;
      else if (mb_clr) irq_modem <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_port <= HB_RESET;
      mb_port <= MB_RESET;
    end else if (reg_we) begin
      if (reg_sel == REG_HB) hb_port <= h_wdata[AW-1:0];
      if (reg_sel == REG_MB) mb_port <= h_wdata[AW-1:0];
    end
  end

  always_comb begin
    case (reg_sel)
      REG_HB:  reg_q = {{(DATA_W-AW){1'b0}}, hb_port};
      REG_MB:  reg_q = {{(DATA_W-AW){1'b0}}, mb_port};
      default: reg_q = '0;
    endcase
  end

  // R6: host interrupt rises only on a nonzero modem write, falls only on a clear
  a_r6_host_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_host) |-> $past(m_wr && (|m_wdata)));
  a_r6_host_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_host) |-> $past(reg_we && reg_sel == REG_CLR));
  // R7: modem interrupt rises on a host bit-0 write, falls on a modem bit-0 write
  a_r7_modem_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_modem) |-> $past(h_wr && h_wdata[0]));
  a_r7_modem_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_modem) |-> $past(m_wr && m_wdata[0]));
  // R10: a doorbell hit on the host-bound word leaves the interrupt high even with a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_word == hb_port && (|m_wdata) && reg_we && reg_sel == REG_CLR) |=> irq_host);
  // R9: doorbell words move only through their own register writes
  a_r9_hb_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel == REG_HB) |=> $stable(hb_port));
  a_r9_mb_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel == REG_MB) |=> $stable(mb_port));
endmodule

// File: rtl/mbx_dualport.sv
module mbx_dualport
  import mbx_pkg::*;
#(
  parameter int AW      = 11,
  parameter bit HAS_MUX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_req_write,
  input  logic [AW+1:0]     h_req_addr,
  input  logic [DATA_W-1:0] h_req_wdata,
  output logic              h_rsp_valid,
  input  logic              h_rsp_ready,
  output logic [DATA_W-1:0] h_rsp_rdata,
  input  logic              m_mux,
  input  logic              m_adv,
  input  logic              m_cs,
  input  logic              m_we,
  input  logic              m_oe,
  input  logic [AW-1:0]     m_addr,
  input  logic [DATA_W-1:0] m_din,
  output logic [DATA_W-1:0] m_dout,
  output logic              irq_host,
  output logic              irq_modem
);
  logic              hm_we, hm_re, reg_we;
  logic [AW-1:0]     hm_word;
  logic [DATA_W-1:0] hm_wdata, hm_q, reg_q;
  mbx_reg_e          reg_sel;
  logic              mm_wr, mm_rd;
  logic [AW-1:0]     mm_word;
  logic [DATA_W-1:0] mm_wdata;

  mbx_host_if #(.AW(AW)) u_host (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready),
    .h_req_write(h_req_write), .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready), .h_rsp_rdata(h_rsp_rdata),
    .mem_we(hm_we), .mem_re(hm_re), .mem_word(hm_word), .mem_wdata(hm_wdata),
    .mem_q(hm_q), .reg_we(reg_we), .reg_sel(reg_sel), .reg_q(reg_q)
  );

  mbx_modem_if #(.AW(AW), .HAS_MUX(HAS_MUX)) u_modem (
    .clk(clk), .rst_n(rst_n), .m_mux(m_mux), .m_adv(m_adv),
    .m_cs(m_cs), .m_we(m_we), .m_oe(m_oe), .m_addr(m_addr), .m_din(m_din),
    .acc_wr(mm_wr), .acc_rd(mm_rd), .acc_word(mm_word), .acc_wdata(mm_wdata)
  );

  mbx_store #(.AW(AW)) u_store (
    .clk(clk),
    .h_we(hm_we), .h_re(hm_re), .h_word(hm_word), .h_wdata(hm_wdata), .h_q(hm_q),
    .m_we(mm_wr), .m_re(mm_rd), .m_word(mm_word), .m_wdata(mm_wdata), .m_q(m_dout)
  );

  mbx_doorbell #(.AW(AW)) u_bell (
    .clk(clk), .rst_n(rst_n),
    .h_wr(hm_we), .h_word(hm_word), .h_wdata(h_req_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_q(reg_q),
    .m_wr(mm_wr), .m_word(mm_word), .m_wdata(mm_wdata),
    .irq_host(irq_host), .irq_modem(irq_modem)
  );
endmodule

// File: tb/mbx_dualport_test.sv
`timescale 1ns/1ps
module mbx_dualport_test;
  localparam int AW = 11;
  localparam logic [AW+1:0] RBASE = 13'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_req_valid = 0, h_req_write = 0, h_rsp_ready = 1;
  logic [AW+1:0] h_req_addr = '0;
  logic [15:0] h_req_wdata = '0;
  logic h_req_ready, h_rsp_valid;
  logic [15:0] h_rsp_rdata;
  logic m_mux = 0, m_adv = 0, m_cs = 0, m_we = 0, m_oe = 0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_din = '0, m_dout;
  logic irq_host, irq_modem;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  mbx_dualport #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_write(h_req_write),
    .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready), .h_rsp_rdata(h_rsp_rdata),
    .m_mux(m_mux), .m_adv(m_adv), .m_cs(m_cs), .m_we(m_we), .m_oe(m_oe),
    .m_addr(m_addr), .m_din(m_din), .m_dout(m_dout),
    .irq_host(irq_host), .irq_modem(irq_modem)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for host read responses
  always @(negedge clk) begin
    if (rst_n && h_rsp_valid && h_rsp_ready) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R3: unexpected response %h expected none", h_rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), h_rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic host_wr(input logic [AW+1:0] a, input logic [15:0] d);
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_addr = a; h_req_wdata = d;
    while (!h_req_ready) @(negedge clk);
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0;
  endtask

  task automatic host_rd(input logic [AW+1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    h_req_valid = 1; h_req_write = 0; h_req_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    while (!h_req_ready) @(negedge clk);
    @(negedge clk);
    h_req_valid = 0;
  endtask

  task automatic mdm_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    m_cs = 1; m_we = 1; m_addr = a; m_din = d;
    @(negedge clk);
    m_cs = 0; m_we = 0;
  endtask

  task automatic mdm_rd(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    m_cs = 1; m_oe = 1; m_addr = a;
    @(negedge clk);
    m_cs = 0; m_oe = 0;
    chk(tag, m_dout, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_host", {15'd0, irq_host}, 16'd0);
    chk("R1 irq_modem", {15'd0, irq_modem}, 16'd0);
    host_rd(RBASE | 13'h4, 16'h07FF, "R1 hb default");
    host_rd(RBASE | 13'h8, 16'h07FE, "R1 mb default");
    host_rd(RBASE | 13'h0, 16'h0000, "R9 clr reads zero");

    // R2 / R4 address translation both ways
    host_wr(13'h0100, 16'h1234);
    mdm_rd(11'h080, 16'h1234, "R2 host->modem");
    host_rd(13'h0101, 16'h1234, "R2 bit0 ignored");
    mdm_wr(11'h010, 16'hBEEF);
    host_rd(13'h0020, 16'hBEEF, "R2 modem->host");
    mdm_rd(11'h010, 16'hBEEF, "R4 modem readback");

    // R3 back-pressure: stalled response holds while the word changes underneath
    host_wr(13'h0040, 16'hA5A5);
    @(posedge clk); #1 h_rsp_ready = 0;
    @(negedge clk);
    h_req_valid = 1; h_req_write = 0; h_req_addr = 13'h0040;
    exp_q.push_back(16'hA5A5); tag_q.push_back("R3 stalled data");
    @(negedge clk);
    h_req_valid = 0;
    chk("R3 ready low in stall", {15'd0, h_req_ready}, 16'd0);
    held = h_rsp_rdata;
    mdm_wr(11'h020, 16'h5A5A);
    repeat (2) @(negedge clk);
    chk("R3 valid held", {15'd0, h_rsp_valid}, 16'd1);
    chk("R3 data held", h_rsp_rdata, held);
    @(posedge clk); #1 h_rsp_ready = 1;
    repeat (2) @(negedge clk);
    host_rd(13'h0040, 16'h5A5A, "R3 new data after stall");

    // R5 shared-bus mode
    @(negedge clk);
    m_mux = 1; m_adv = 1; m_cs = 1; m_we = 1; m_din = 16'h0123;
    @(negedge clk);
    m_adv = 0; m_addr = 11'h555; m_din = 16'hC0DE;
    @(negedge clk);
    m_cs = 0; m_we = 0;
    host_rd(13'h0246, 16'hC0DE, "R5 latched address write");
    host_rd(13'h0AAA, 16'h0000 | 16'h0000, "R5 m_addr ignored");
    @(negedge clk);
    m_cs = 1; m_oe = 1; m_addr = 11'h000;
    @(negedge clk);
    m_cs = 0; m_oe = 0;
    chk("R5 latched address read", m_dout, 16'hC0DE);
    m_mux = 0;

    // R6 host-bound doorbell
    mdm_wr(11'h7FF, 16'h0000);
    chk("R6 zero write ignored", {15'd0, irq_host}, 16'd0);
    mdm_wr(11'h7FF, 16'h0005);
    chk("R6 set", {15'd0, irq_host}, 16'd1);
    chk("R6 other irq untouched", {15'd0, irq_modem}, 16'd0);
    host_rd(13'h0FFE, 16'h0005, "R8 host-bound code stored");
    host_wr(RBASE, 16'h0000);
    chk("R6 clear", {15'd0, irq_host}, 16'd0);

    // R7 modem-bound doorbell
    host_wr(13'h0FFC, 16'h0002);
    chk("R7 bit0 clear ignored", {15'd0, irq_modem}, 16'd0);
    host_wr(13'h0FFC, 16'h0003);
    chk("R7 set", {15'd0, irq_modem}, 16'd1);
    mdm_rd(11'h7FE, 16'h0003, "R8 modem-bound code stored");
    mdm_wr(11'h7FE, 16'h0002);
    chk("R7 modem bit0 zero keeps", {15'd0, irq_modem}, 16'd1);
    mdm_wr(11'h7FE, 16'h0001);
    chk("R7 clear", {15'd0, irq_modem}, 16'd0);

    // R9 reprogram both doorbell words
    host_wr(RBASE | 13'h4, 16'h0055);
    host_wr(RBASE | 13'h8, 16'h0066);
    host_rd(RBASE | 13'h4, 16'h0055, "R9 hb readback");
    host_rd(RBASE | 13'h8, 16'h0066, "R9 mb readback");
    mdm_wr(11'h7FF, 16'h0009);
    chk("R9 old hb is plain", {15'd0, irq_host}, 16'd0);
    host_wr(13'h0FFC, 16'h0001);
    chk("R9 old mb is plain", {15'd0, irq_modem}, 16'd0);
    mdm_wr(11'h055, 16'h0001);
    chk("R9 new hb sets", {15'd0, irq_host}, 16'd1);

    // R10 set and clear together on the host-bound interrupt
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_addr = RBASE; h_req_wdata = 16'h0;
    m_cs = 1; m_we = 1; m_addr = 11'h055; m_din = 16'h0007;
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0; m_cs = 0; m_we = 0;
    chk("R10 host irq set wins", {15'd0, irq_host}, 16'd1);
    host_wr(RBASE, 16'hFFFF);
    chk("R6 clear any value", {15'd0, irq_host}, 16'd0);

    // R10 + R11 same-word collision on the modem-bound doorbell
    host_wr(13'h00CC, 16'h0001);
    chk("R9 new mb sets", {15'd0, irq_modem}, 16'd1);
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_addr = 13'h00CC; h_req_wdata = 16'h0011;
    m_cs = 1; m_we = 1; m_addr = 11'h066; m_din = 16'h0021;
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0; m_cs = 0; m_we = 0;
    chk("R10 modem irq set wins", {15'd0, irq_modem}, 16'd1);
    host_rd(13'h00CC, 16'h0011, "R11 host data kept");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R3: got %0d pending responses expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule